// File: doc/BRIEF.md
# Pipelined Ternary Match Table

A register-built ternary lookup table. Each of its DEPTH entries holds a compare value, a care mask, a live flag and a result word. A search key is compared against every live entry. Key bits whose care bit is clear are wildcards. The block reports whether any entry matched, together with the result word of the matching entry that has the lowest index.

The entries are split into ROWS rows of UNITS units. Each unit owns DEPTH/(ROWS·UNITS) consecutive entries and is STAGES registers deep. The units of a row pass the row's partial match vector from one to the next, so a row's full vector is ready UNITS·STAGES cycles after the key enters. One further register stage selects the winning entry, and one registers the output. Every search therefore completes in exactly UNITS·STAGES+2 cycles.

Keys enter on a valid/ready handshake. `in_ready` is low only in a cycle in which the write port is active, and that cycle's key waits until a later cycle. Results leave on a plain valid strobe with no back-pressure, and a new key may be accepted in every cycle. A write takes effect for every key accepted in a later cycle.

Top module: `tcam_lookup`

## Requirements
- R1: A key is accepted on a rising edge where `in_valid` and `in_ready` are both high; `in_ready` is low in exactly the cycles where `wr_en` is high, and a key offered then produces no result.
- R2: For every accepted key, `out_valid` is high for one cycle exactly UNITS·STAGES+2 rising edges after the accepting edge (6 at the default parameters); `out_valid` is never high otherwise.
- R3: An entry matches when it is live and, for every bit whose care-mask bit is 1, the key bit equals the compare-value bit; care-mask bits of 0 match either key value.
- R4: When several entries match, the result of the lowest-indexed one is returned.
- R5: A search that matches no entry returns `out_hit`=0 and `out_result`=0.
- R6: An entry written with `wr_live`=0 never matches, whatever its value and mask.
- R7: Keys accepted on consecutive cycles yield results on consecutive cycles, in acceptance order.
- R8: A write on one edge is seen by a key accepted on any later edge, both when it adds a matching entry and when it removes one.
- R9: After reset every entry is dead, `out_valid` is 0 and `in_ready` is 1.
- R10: Entries in every row and unit take part in the search, including index DEPTH-1 in the last unit of the last row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Search key offered |
| in_ready | output | 1 | Key can be taken this cycle |
| in_key | input | KEY_W | Search key |
| wr_en | input | 1 | Write one entry this cycle |
| wr_addr | input | $clog2(DEPTH) | Entry index written |
| wr_live | input | 1 | Live flag stored with the entry |
| wr_value | input | KEY_W | Compare value |
| wr_care | input | KEY_W | Care mask, 1 = bit must equal |
| wr_result | input | RES_W | Result word for the entry |
| out_valid | output | 1 | Search result present |
| out_hit | output | 1 | At least one entry matched |
| out_result | output | RES_W | Result word of the winning entry, 0 on a miss |

## Verification
Each result falls due six edges after its key is accepted. The bench records the cycle count at each accepting edge and at each output strobe, and requires every pair to differ by exactly that amount. Outputs are sampled on the falling edge, after all registers on the path have settled, and the results of a back-to-back burst must arrive on consecutive cycles. A key offered during a write, and a search placed right after a write, are each judged a full latency later.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  localparam int unsigned MAX_KEY_W     = 64;
  localparam int unsigned DEF_KEY_W     = 16;
  localparam int unsigned DEF_RES_W     = 8;
  localparam int unsigned DEF_DEPTH     = 16;
  localparam int unsigned DEF_ROWS      = 2;
  localparam int unsigned DEF_UNITS     = 2;
  localparam int unsigned DEF_STAGES    = 2;

  // ternary compare on zero-extended operands
  function automatic logic ternary_hit(
    input logic                 live,
    input logic [MAX_KEY_W-1:0] key,
    input logic [MAX_KEY_W-1:0] val,
    input logic [MAX_KEY_W-1:0] care
  );
    return live && (((key ^ val) & care) == '0);
  endfunction

endpackage

// File: rtl/tcam_unit.sv
module tcam_unit
  import tcam_pkg::*;
#(
  parameter int unsigned KEY_W  = DEF_KEY_W,
  parameter int unsigned EPU    = 4,
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned OFFSET = 0,
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [KEY_W-1:0]          key_i,
  input  logic [ROW_W-1:0]          vec_i,
  input  logic [EPU-1:0]            live_i,
  input  logic [EPU-1:0][KEY_W-1:0] val_i,
  input  logic [EPU-1:0][KEY_W-1:0] care_i,
  output logic [ROW_W-1:0]          vec_o
);

  localparam int unsigned XW = MAX_KEY_W;

  logic [EPU-1:0]   hits;
  logic [ROW_W-1:0] merged;
  logic [ROW_W-1:0] st [STAGES];

  always_comb begin
    for (int e = 0; e < int'(EPU); e++) begin
      hits[e] = ternary_hit(live_i[e], XW'(key_i), XW'(val_i[e]), XW'(care_i[e]));
    end
  end

  // own slice joins the partial vector handed down the row
  assign merged = vec_i | (ROW_W'(hits) << OFFSET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) st[s] <= '0;
    end else begin
      st[0] <= merged;
      for (int s = 1; s < int'(STAGES); s++) st[s] <= st[s-1];
    end
  end

  assign vec_o = st[STAGES-1];

endmodule

// File: rtl/tcam_resolve.sv
module tcam_resolve
  import tcam_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned RES_W = DEF_RES_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      vld_i,
  input  logic [DEPTH-1:0]          hits_i,
  input  logic [DEPTH-1:0][RES_W-1:0] res_i,
  output logic                      out_valid,
  output logic                      out_hit,
  output logic [RES_W-1:0]          out_result
);

  logic             f_hit;
  logic [IDX_W-1:0] f_idx;
  logic             pe_vld, pe_hit;
  logic [IDX_W-1:0] pe_idx;

  // lowest index wins: scan downward, last assignment stands
  always_comb begin
    f_hit = 1'b0;
    f_idx = '0;
    for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
      if (hits_i[i]) begin
        f_hit = 1'b1;
        f_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_vld <= 1'b0;
      pe_hit <= 1'b0;
      pe_idx <= '0;
    end else begin
      pe_vld <= vld_i;
      pe_hit <= vld_i && f_hit;
      pe_idx <= f_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid  <= pe_vld;
      out_hit    <= pe_vld && pe_hit;
      out_result <= (pe_vld && pe_hit) ? res_i[pe_idx] : '0;
    end
  end

endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
  import tcam_pkg::*;
#(
  parameter int unsigned KEY_W  = DEF_KEY_W,
  parameter int unsigned RES_W  = DEF_RES_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned ROWS   = DEF_ROWS,
  parameter int unsigned UNITS  = DEF_UNITS,
  parameter int unsigned STAGES = DEF_STAGES,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [KEY_W-1:0] in_key,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic             wr_live,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_care,
  input  logic [RES_W-1:0] wr_result,
  output logic             out_valid,
  output logic             out_hit,
  output logic [RES_W-1:0] out_result
);

  localparam int unsigned EPU   = DEPTH / (ROWS * UNITS);
  localparam int unsigned ROW_W = UNITS * EPU;
  localparam int unsigned LH    = UNITS * STAGES;
  localparam int unsigned KPN   = (UNITS > 1) ? (UNITS - 1) * STAGES : 1;

  // entry storage
  logic [DEPTH-1:0]            ent_live;
  logic [DEPTH-1:0][KEY_W-1:0] ent_val;
  logic [DEPTH-1:0][KEY_W-1:0] ent_care;
  logic [DEPTH-1:0][RES_W-1:0] ent_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_live <= '0;
      ent_val  <= '0;
      ent_care <= '0;
      ent_res  <= '0;
    end else if (wr_en) begin
      ent_live[wr_addr] <= wr_live;
      ent_val[wr_addr]  <= wr_value;
      ent_care[wr_addr] <= wr_care;
      ent_res[wr_addr]  <= wr_result;
    end
  end

  // intake: a write cycle holds the key back
  logic accept;
  assign in_ready = !wr_en;
  assign accept   = in_valid && in_ready;

  // shared key and valid delay lines
  logic [KEY_W-1:0] key_sr [KPN];
  logic [LH-1:0]    vld_sr;

  always_ff @(posedge clk) begin
    for (int j = 0; j < int'(KPN); j++) begin
      key_sr[j] <= (j == 0) ? in_key : key_sr[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_sr <= '0;
    else        vld_sr <= (vld_sr << 1) | LH'(accept);
  end

  // rows of cascaded units
  logic [ROW_W-1:0] row_hits [ROWS];
  logic [DEPTH-1:0] all_hits;

  for (genvar r = 0; r < int'(ROWS); r++) begin : g_row
    logic [ROW_W-1:0] cv [UNITS+1];
    assign cv[0] = '0;

    for (genvar u = 0; u < int'(UNITS); u++) begin : g_unit
      localparam int unsigned BASE = r * ROW_W + u * EPU;
      logic [KEY_W-1:0] ukey;

      if (u == 0) begin : g_k0
        assign ukey = in_key;
      end else begin : g_kn
        assign ukey = key_sr[u*STAGES-1];
      end

      tcam_unit #(
        .KEY_W (KEY_W),
        .EPU   (EPU),
        .ROW_W (ROW_W),
        .OFFSET(u * EPU),
        .STAGES(STAGES)
      ) u_unit (
        .clk   (clk),
        .rst_n (rst_n),
        .key_i (ukey),
        .vec_i (cv[u]),
        .live_i(ent_live[BASE +: EPU]),
        .val_i (ent_val[BASE +: EPU]),
        .care_i(ent_care[BASE +: EPU]),
        .vec_o (cv[u+1])
      );
    end

    assign row_hits[r] = cv[UNITS];
  end

  always_comb begin
    for (int r = 0; r < int'(ROWS); r++) begin
      all_hits[r*ROW_W +: ROW_W] = row_hits[r];
    end
  end

  tcam_resolve #(
    .DEPTH(DEPTH),
    .RES_W(RES_W)
  ) u_resolve (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld_i     (vld_sr[LH-1]),
    .hits_i    (all_hits),
    .res_i     (ent_res),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_result(out_result)
  );

endmodule

// File: rtl/tcam_lookup_chk.sv
module tcam_lookup_chk #(
  parameter int unsigned RES_W  = 8,
  parameter int unsigned UNITS  = 2,
  parameter int unsigned STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             wr_en,
  input logic             out_valid,
  input logic             out_hit,
  input logic [RES_W-1:0] out_result
);

  localparam int unsigned LAT = UNITS * STAGES + 2;

  // acceptance history, one bit per cycle in flight
  logic [LAT-1:0] acc_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_hist <= '0;
    else        acc_hist <= (acc_hist << 1) | LAT'(in_valid && in_ready);
  end

  // R1
  write_blocks_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !in_ready);

  // R2
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == acc_hist[LAT-1]);

  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_result == '0));

  // R2
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_valid);

  // R5
  idle_result_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_result == '0));

endmodule

bind tcam_lookup tcam_lookup_chk #(
  .RES_W (RES_W),
  .UNITS (UNITS),
  .STAGES(STAGES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .wr_en     (wr_en),
  .out_valid (out_valid),
  .out_hit   (out_hit),
  .out_result(out_result)
);

// File: tb/sim_tcam_lookup.sv
`timescale 1ns/1ps
module sim_tcam_lookup;

  localparam int KW  = 16;
  localparam int RW  = 8;
  localparam int D   = 16;
  localparam int NR  = 2;
  localparam int NU  = 2;
  localparam int NH  = 2;
  localparam int AW  = 4;
  localparam int LAT = NU * NH + 2;
  localparam int NV  = 10;

  // {key, hit, result, requirement}
  localparam logic [28:0] VEC [NV] = '{
    {16'h1234, 1'b1, 8'h10, 4'd4},
    {16'h12FF, 1'b1, 8'h10, 4'd3},
    {16'h34AB, 1'b1, 8'h33, 4'd3},
    {16'h12AB, 1'b1, 8'h10, 4'd4},
    {16'h5555, 1'b0, 8'h00, 4'd6},
    {16'hA123, 1'b1, 8'h99, 4'd3},
    {16'hAAAB, 1'b1, 8'h33, 4'd4},
    {16'hBEEF, 1'b1, 8'hF5, 4'd10},
    {16'hBEEE, 1'b0, 8'h00, 4'd5},
    {16'h0000, 1'b0, 8'h00, 4'd5}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [KW-1:0] in_key = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic          wr_live = 1'b0;
  logic [KW-1:0] wr_value = '0;
  logic [KW-1:0] wr_care = '0;
  logic [RW-1:0] wr_result = '0;
  logic          out_valid;
  logic          out_hit;
  logic [RW-1:0] out_result;

  always #4 clk = ~clk;

  tcam_lookup #(
    .KEY_W(KW), .RES_W(RW), .DEPTH(D), .ROWS(NR), .UNITS(NU), .STAGES(NH)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .wr_en(wr_en), .wr_addr(wr_addr), .wr_live(wr_live),
    .wr_value(wr_value), .wr_care(wr_care), .wr_result(wr_result),
    .out_valid(out_valid), .out_hit(out_hit), .out_result(out_result)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int got_n = 0;
  int acc_n = 0;
  logic          got_hit [64];
  logic [RW-1:0] got_res [64];
  int            got_cyc [64];
  int            acc_cyc [64];

  // monitor: falling edge, registers settled
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (out_valid && got_n < 64) begin
      got_hit[got_n] = out_hit;
      got_res[got_n] = out_result;
      got_cyc[got_n] = cyc;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [KW-1:0] k);
    @(negedge clk); #1;
    wr_en = 1'b0;
    in_valid = 1'b1;
    in_key = k;
    #1;
    if (in_ready && acc_n < 64) begin
      acc_cyc[acc_n] = cyc;
      acc_n++;
    end
  endtask

  task automatic put(input logic [AW-1:0] a, input logic lv, input logic [KW-1:0] v,
                     input logic [KW-1:0] c, input logic [RW-1:0] r);
    @(negedge clk); #1;
    in_valid = 1'b0;
    wr_en = 1'b1; wr_addr = a; wr_live = lv;
    wr_value = v; wr_care = c; wr_result = r;
  endtask

  task automatic idle(input int n);
    @(negedge clk); #1;
    in_valid = 1'b0;
    wr_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // check one result: hit, result word and latency (R2)
  task automatic check_out(input int i, input string req, input logic h, input logic [RW-1:0] r);
    chk(req, $sformatf("hit #%0d", i), int'(got_hit[i]), int'(h));
    chk(req, $sformatf("result #%0d", i), int'(got_res[i]), int'(r));
    chk("R2", $sformatf("latency #%0d", i), got_cyc[i] - acc_cyc[i], LAT);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "out_valid in reset", int'(out_valid), 0);
    chk("R9", "in_ready in reset", int'(in_ready), 1);
    @(negedge clk); #1;
    rst_n = 1'b1;

    // R9: empty table misses
    send(16'h1234);
    idle(LAT + 2);
    chk("R9", "outputs after one key", got_n, 1);
    check_out(0, "R9", 1'b0, 8'h00);

    // load table
    put(4'd0,  1'b1, 16'h1200, 16'hFF00, 8'h10);
    put(4'd1,  1'b1, 16'h1234, 16'hFFFF, 8'h11);
    put(4'd3,  1'b1, 16'h00AB, 16'h00FF, 8'h33);
    put(4'd5,  1'b0, 16'h5555, 16'hFFFF, 8'h55);
    put(4'd9,  1'b1, 16'hA000, 16'hF000, 8'h99);
    put(4'd15, 1'b1, 16'hBEEF, 16'hFFFF, 8'hF5);
    idle(1);

    // R7: vector table back to back; covers R3 R4 R5 R6 R10
    base = got_n;
    for (int i = 0; i < NV; i++) send(VEC[i][28:13]);
    idle(LAT + 2);
    chk("R7", "burst output count", got_n - base, NV);
    for (int i = 0; i < NV; i++) begin
      check_out(base + i, $sformatf("R%0d", VEC[i][3:0]), VEC[i][12], VEC[i][11:4]);
      if (i > 0)
        chk("R7", $sformatf("spacing #%0d", i), got_cyc[base+i] - got_cyc[base+i-1], 1);
    end

    // R1: key offered during a write is held off
    @(negedge clk); #1;
    in_valid = 1'b1; in_key = 16'h1234;
    wr_en = 1'b1; wr_addr = 4'd14; wr_live = 1'b1;
    wr_value = 16'h0000; wr_care = 16'h0000; wr_result = 8'hEE;
    #1;
    chk("R1", "in_ready during write", int'(in_ready), 0);
    base = got_n;
    idle(LAT + 2);
    chk("R1", "no result for blocked key", got_n - base, 0);

    // R8: wildcard entry written above is visible next cycle
    base = got_n;
    send(16'h0000);
    send(16'h1234);
    idle(LAT + 2);
    chk("R8", "count after add", got_n - base, 2);
    check_out(base, "R8", 1'b1, 8'hEE);
    check_out(base + 1, "R4", 1'b1, 8'h10);

    // R8: removal right before a key
    base = got_n;
    put(4'd14, 1'b0, 16'h0000, 16'h0000, 8'hEE);
    send(16'h0000);
    idle(LAT + 2);
    chk("R8", "count after remove", got_n - base, 1);
    check_out(base, "R8", 1'b0, 8'h00);

    // R10: last entry alone after lower ones die
    put(4'd0, 1'b0, 16'h0, 16'h0, 8'h0);
    put(4'd15, 1'b1, 16'h0000, 16'h0000, 8'hC3);
    base = got_n;
    send(16'h1234);
    idle(LAT + 2);
    check_out(base, "R4", 1'b1, 8'h11);
    base = got_n;
    send(16'h7777);
    idle(LAT + 2);
    check_out(base, "R10", 1'b1, 8'hC3);

    // R2: no output without an accepted key
    chk("R2", "outputs equal accepted keys", got_n, acc_n);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule